// File: doc/BRIEF.md
# Serial Port FIFO Pair with Occupancy Index

This block is the buffering stage between a serial port's register interface and its bit-level transmitter and receiver. Software writes bytes into a transmit FIFO through a data address. The transmitter drains that FIFO one byte at a time. The receiver pushes characters into a receive FIFO, each tagged with parity-error and framing-error flags, and software reads them back through the same data address.

A read-only index register reports the fill level of both FIFOs. A control register switches between FIFO mode and single-character mode. The same register starts flushes that clear themselves. A line-control input selects whether a read of an empty receive FIFO is reported as a bus error.

Register decoding uses a 2-bit address. Address 0 is the data port, address 1 is the index, address 2 is the control register, and address 3 reads as zero. Reads are combinational: `reg_rdata` and `reg_err` are valid in the cycle `reg_rd` is high. Any pop happens at the closing clock edge.

Top module: `uart_fifo_regs`

## Requirements
- R1: After reset, both FIFOs are empty, the control register reads 0 (FIFO mode off, no flush pending), and neither overflow output is high.
- R2: A read of address 1 returns the transmit count in bits 4:0 and the receive count in bits 12:8, each from 0 to 16, with all other bits 0.
- R3: Bytes written to address 0 leave on `tx_data` in the order written. `tx_avail` is high whenever the transmit FIFO holds data, and `tx_pop` removes the oldest byte at the clock edge.
- R4: Control bit 0 selects FIFO mode. When it is 1, each FIFO accepts up to 16 entries. When it is 0, each FIFO accepts only 1 entry.
- R5: Writing the control register with bit 2 set flushes the transmit FIFO, and with bit 3 set flushes the receive FIFO. In the cycle after the write, those bits read back as 1 and the counts are unchanged. At the next edge the flushed FIFO is empty, pushes in that same cycle are discarded, and the bits read 0.
- R6: A read of address 0 with data in the receive FIFO returns the oldest entry: data in bits 7:0, the parity-error flag in bit 8 and the framing-error flag in bit 9. That entry is removed at the edge.
- R7: A read of address 0 with the receive FIFO empty returns 0 and changes no count. `reg_err` is high during that read when `rd_empty_err_en` is 1, and stays low when it is 0.
- R8: A write to address 0 is dropped when the transmit count, taken before the edge, is already at capacity, even if `tx_pop` is high in the same cycle. `tx_ovf` then pulses high for the one cycle after the write.
- R9: A receive push is dropped when the receive count, taken before the edge, is already at capacity. `rx_ovf` then pulses high for the one cycle after the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 data, 1 index, 2 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while `reg_rd` is high |
| reg_err | output | 1 | Bus error for an empty receive read |
| rd_empty_err_en | input | 1 | Line-control option that enables `reg_err` |
| tx_avail | output | 1 | Transmit FIFO holds data |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Transmitter takes `tx_data` |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| tx_ovf | output | 1 | Transmit write dropped (one-cycle pulse) |
| rx_ovf | output | 1 | Receive push dropped (one-cycle pulse) |

## Verification
The hardest state to reach is a flush that is pending while the same FIFO sees a push, a pop and, in the opposite mode, a full condition. This is a one-cycle window that the ports only expose through the control readback. The stimulus fills both FIFOs to 16 and pushes further to force drops. It then flushes with traffic in the pending cycle and toggles FIFO mode while entries are held. A long random phase with a fixed seed keeps repeating flush, mode-change and full-FIFO collisions against a queue model.

// File: rtl/uart_fifo_pkg.sv
// Shared register addresses and control bit positions for the FIFO pair.
package uart_fifo_pkg;
    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_INDEX = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_TXFL_BIT  = 2;
    localparam int CTRL_RXFL_BIT  = 3;

    localparam int IDX_TX_LSB = 0;
    localparam int IDX_RX_LSB = 8;
endpackage

// File: rtl/fifo_store.sv
// Synchronous FIFO with occupancy count, a one-entry capacity mode and a
// clear input that overrides push and pop. Assumes DEPTH is a power of two.
module fifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          one_slot,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    // Capacity test against the count held before this edge.
    always_comb begin
        full    = one_slot ? (count != '0) : (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        drop    = push && full;
        dout    = mem[rd_ptr];
    end

    // Pointer and count update; a clear empties the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/fifo_ctrl.sv
// FIFO control register: holds the mode bit and the two flush requests.
// Each flush request lives for exactly one cycle after its write.
module fifo_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [15:0] wdata,
    output logic        fifo_en,
    output logic        tx_pend,
    output logic        rx_pend
);
    import uart_fifo_pkg::*;

    // Mode bit holds its value; flush bits clear the cycle after they are set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            tx_pend <= 1'b0;
            rx_pend <= 1'b0;
        end else if (ctrl_wr) begin
            fifo_en <= wdata[CTRL_EN_BIT];
            tx_pend <= wdata[CTRL_TXFL_BIT];
            rx_pend <= wdata[CTRL_RXFL_BIT];
        end else begin
            tx_pend <= 1'b0;
            rx_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fifo_regs.sv
// FIFO pair for a serial port: transmit and receive storage, index and
// control registers, empty-read error option and overflow pulses.
// Assumes at most one of reg_wr / reg_rd per cycle.
module uart_fifo_regs #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int RX_W  = DATA_W + 2,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              reg_err,
    input  logic              rd_empty_err_en,
    output logic              tx_avail,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              tx_ovf,
    output logic              rx_ovf
);
    import uart_fifo_pkg::*;

    logic            fifo_en, tx_pend, rx_pend;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_empty, rx_empty, tx_drop, rx_drop;
    logic [RX_W-1:0] rx_head;
    logic            data_wr, data_rd, ctrl_wr;

    // Register strobe decode.
    always_comb begin
        data_wr = reg_wr && (reg_addr == ADDR_DATA);
        data_rd = reg_rd && (reg_addr == ADDR_DATA);
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    end

    fifo_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (reg_wdata),
        .fifo_en (fifo_en),
        .tx_pend (tx_pend),
        .rx_pend (rx_pend)
    );

    fifo_store #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_pend),
        .one_slot (!fifo_en),
        .push     (data_wr),
        .din      (reg_wdata[DATA_W-1:0]),
        .pop      (tx_pop),
        .dout     (tx_data),
        .count    (tx_cnt),
        .empty    (tx_empty),
        .drop     (tx_drop)
    );

    fifo_store #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_pend),
        .one_slot (!fifo_en),
        .push     (rx_push),
        .din      ({rx_ferr, rx_perr, rx_data}),
        .pop      (data_rd),
        .dout     (rx_head),
        .count    (rx_cnt),
        .empty    (rx_empty),
        .drop     (rx_drop)
    );

    assign tx_avail = !tx_empty;

    // Read data multiplexer and empty-read error.
    always_comb begin
        reg_rdata = '0;
        reg_err   = 1'b0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_DATA: begin
                    if (!rx_empty) reg_rdata[RX_W-1:0] = rx_head;
                    else           reg_err = rd_empty_err_en;
                end
                ADDR_INDEX: begin
                    reg_rdata[IDX_TX_LSB +: CW] = tx_cnt;
                    reg_rdata[IDX_RX_LSB +: CW] = rx_cnt;
                end
                ADDR_CTRL: begin
                    reg_rdata[CTRL_EN_BIT]   = fifo_en;
                    reg_rdata[CTRL_TXFL_BIT] = tx_pend;
                    reg_rdata[CTRL_RXFL_BIT] = rx_pend;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    // One-cycle overflow pulses for the interrupt logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            tx_ovf <= tx_drop;
            rx_ovf <= rx_drop;
        end
    end
endmodule

// File: rtl/uart_fifo_regs_chk.sv
// Property checker for uart_fifo_regs, attached by bind below.
module uart_fifo_regs_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic          rd_empty_err_en,
    input logic          reg_err,
    input logic          tx_ovf,
    input logic          rx_push,
    input logic          rx_ovf,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          tx_pend,
    input logic          rx_pend
);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend |=> (tx_cnt == '0));

    p_rx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend |=> (rx_cnt == '0));

    p_empty_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rd && reg_addr == 2'd0 && rx_cnt == '0 && rd_empty_err_en));

    p_tx_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> $past(reg_wr && reg_addr == 2'd0 && tx_cnt != '0));

    p_rx_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> $past(rx_push && rx_cnt != '0));
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_addr        (reg_addr),
    .rd_empty_err_en (rd_empty_err_en),
    .reg_err         (reg_err),
    .tx_ovf          (tx_ovf),
    .rx_push         (rx_push),
    .rx_ovf          (rx_ovf),
    .tx_cnt          (tx_cnt),
    .rx_cnt          (rx_cnt),
    .tx_pend         (tx_pend),
    .rx_pend         (rx_pend)
);

// File: tb/uart_fifo_regs_tb.sv
module uart_fifo_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_err, rd_empty_err_en;
    logic        tx_avail, tx_pop, rx_push, rx_perr, rx_ferr, tx_ovf, rx_ovf;
    logic [7:0]  tx_data, rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_regs u_dut (.*);

    logic [7:0] tq [$];
    logic [9:0] rq [$];
    bit   m_en, m_ptx, m_prx, e_txovf, e_rxovf;
    int   checks = 0, errors = 0;
    bit   done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_index();
        return {3'b0, 5'(rq.size()), 3'b0, 5'(tq.size())};
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (!reg_rd) return 16'h0;
        case (reg_addr)
            2'd0: return (rq.size() != 0) ? {6'b0, rq[0]} : 16'h0;
            2'd1: return exp_index();
            2'd2: return {12'b0, m_prx, m_ptx, 1'b0, m_en};
            default: return 16'h0;
        endcase
    endfunction

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        tx_pop = 0; rx_push = 0; rx_data = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    // Inputs already driven after a negedge; check outputs, advance model.
    task automatic run_cycle();
        int cap, tc, rc;
        bit tpush, tpop, rpush, rpop;
        #1;
        chk("R3 tx_avail", tx_avail, tq.size() != 0);
        if (tq.size() != 0) chk("R3 tx_data", tx_data, tq[0]);
        chk("R8 tx_ovf", tx_ovf, e_txovf);
        chk("R9 rx_ovf", rx_ovf, e_rxovf);
        chk("R7 reg_err", reg_err, reg_rd && reg_addr == 0 && rq.size() == 0 && rd_empty_err_en);
        if (reg_rd) chk("R6/R2/R5 rdata", reg_rdata, exp_rdata());
        @(posedge clk);
        cap = m_en ? 16 : 1;
        tc = tq.size(); rc = rq.size();
        tpush = reg_wr && reg_addr == 0 && tc < cap;
        e_txovf = reg_wr && reg_addr == 0 && tc >= cap;
        tpop = tx_pop && tc > 0;
        rpush = rx_push && rc < cap;
        e_rxovf = rx_push && rc >= cap;
        rpop = reg_rd && reg_addr == 0 && rc > 0;
        if (m_ptx) tq.delete();
        else begin
            if (tpop) void'(tq.pop_front());
            if (tpush) tq.push_back(reg_wdata[7:0]);
        end
        if (m_prx) rq.delete();
        else begin
            if (rpop) void'(rq.pop_front());
            if (rpush) rq.push_back({rx_ferr, rx_perr, rx_data});
        end
        if (reg_wr && reg_addr == 2) begin
            m_en = reg_wdata[0]; m_ptx = reg_wdata[2]; m_prx = reg_wdata[3];
        end else begin
            m_ptx = 0; m_prx = 0;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; run_cycle();
    endtask
    task automatic rd(logic [1:0] a);
        reg_rd = 1; reg_addr = a; run_cycle();
    endtask
    task automatic rpush(logic [7:0] d, logic p, logic f);
        rx_push = 1; rx_data = d; rx_perr = p; rx_ferr = f; run_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(); rd_empty_err_en = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        reg_rd = 1; reg_addr = 2; #1;
        chk("R1 ctrl", reg_rdata, 16'h0);
        reg_addr = 1; #1;
        chk("R1 index", reg_rdata, 16'h0);
        chk("R1 ovf", {tx_ovf, rx_ovf}, 2'b00);
        idle(); run_cycle();

        // R4: FIFO mode off holds one entry
        wr(0, 16'h11); wr(0, 16'h22); rd(1);
        rpush(8'h33, 0, 0); rpush(8'h44, 0, 0); rd(1);
        wr(2, 16'h000C); rd(2); rd(1);
        // R4/R8/R9: FIFO mode on, fill to 16 and beyond
        wr(2, 16'h0001);
        for (int i = 0; i < 18; i++) wr(0, 16'(8'hA0 + i));
        rd(1);
        for (int i = 0; i < 18; i++) rpush(8'(i * 7), i[0], i[1]);
        rd(1);
        // R8: write while full with pop in same cycle is still dropped
        tx_pop = 1; wr(0, 16'h5A);
        // R6: drain some entries
        for (int i = 0; i < 5; i++) rd(0);
        // R5: flush both with traffic in the pending cycle
        wr(2, 16'h000D);
        reg_rd = 1; reg_addr = 2; rx_push = 1; rx_data = 8'h77; tx_pop = 1; run_cycle();
        rd(1); rd(2);
        // R7: empty reads with and without error
        rd_empty_err_en = 1; rd(0);
        rd_empty_err_en = 0; rd(0); rd(1);
        // R4: leave entries in FIFO, then switch mode off
        for (int i = 0; i < 4; i++) wr(0, 16'(i));
        wr(2, 16'h0000); wr(0, 16'hEE); rd(1);
        wr(2, 16'h0001);

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            int k = $urandom_range(99);
            rd_empty_err_en = $urandom_range(1);
            tx_pop = ($urandom_range(3) == 0);
            rx_push = ($urandom_range(2) == 0);
            rx_data = 8'($urandom); rx_perr = $urandom_range(1); rx_ferr = $urandom_range(1);
            if (k < 35) begin reg_wr = 1; reg_addr = 0; reg_wdata = 16'($urandom); end
            else if (k < 70) begin reg_rd = 1; reg_addr = 2'($urandom_range(3)); end
            else if (k < 73) begin
                reg_wr = 1; reg_addr = 2;
                reg_wdata = {12'b0, 1'($urandom), 1'($urandom), 1'b0, ($urandom_range(7) != 0)};
            end
            run_cycle();
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule